// File: doc/BRIEF.md
# Four-Point DFT Butterfly

This block computes the discrete Fourier transform of four complex samples and is meant to sit as the radix-4 butterfly inside a larger FFT datapath. On any cycle where the input strobe is high, it takes four complex samples side by side. Each sample has a 16-bit two's-complement real part and a 16-bit two's-complement imaginary part.

Two cycles later it presents the four transform bins in natural order, with an output strobe and an overflow flag. The arithmetic is two registered add/subtract stages. The quarter-turn rotation that the odd bins need is built from a swap of real and imaginary parts plus a negation, so the block has no multiplier. Any twiddle rotation between butterflies of the larger FFT belongs to the surrounding datapath.

Internal sums carry two guard bits. A bin that does not fit back into 16 bits is clamped to the nearest representable value, and that event is reported on the overflow flag.

Top module: `dft4_butterfly`

## Requirements
- R1: While reset is low at a clock edge, the output strobe and the overflow flag are low after that edge.
- R2: The output strobe is high exactly two clock edges after an edge at which the input strobe was high, and low two edges after an edge at which it was low.
- R3: Bin 0 (lane 0 of the output vectors, bits 15:0) equals a0 + a1 + a2 + a3, taken separately on the real and imaginary parts.
- R4: Bin 2 (lane 2) equals (a0 + a2) − (a1 + a3), taken separately on the real and imaginary parts.
- R5: Bin 1 (lane 1) equals (a0 − a2) − j(a1 − a3). Its real part is (re0 − re2) + (im1 − im3), and its imaginary part is (im0 − im2) − (re1 − re3).
- R6: Bin 3 (lane 3) equals (a0 − a2) + j(a1 − a3). Its real part is (re0 − re2) − (im1 − im3), and its imaginary part is (im0 − im2) + (re1 − re3).
- R7: A new sample set can be accepted on every cycle. Back-to-back sets each produce their own correct result on consecutive cycles.
- R8: A bin component whose exact value exceeds 32767 is output as 32767. One below −32768 is output as −32768. Values exactly at these limits pass unchanged.
- R9: The overflow flag is high, together with the output strobe, exactly when at least one of the eight output components of that result was clamped. Otherwise it is low.
- R10: While the input strobe is low, the output data keep the value of the last valid result, whatever is on the sample inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample set on the inputs is to be transformed |
| in_re | input | 4x16 | Real parts; lane k holds sample k |
| in_im | input | 4x16 | Imaginary parts; lane k holds sample k |
| out_valid | output | 1 | Output bins carry a new result |
| out_re | output | 4x16 | Real parts of bins 0 to 3, lane k holds bin k |
| out_im | output | 4x16 | Imaginary parts of bins 0 to 3 |
| ovfl | output | 1 | At least one component of the current result was clamped |

## Verification
The bench builds the block with its default 16-bit samples and two guard bits, which are the widths the requirements name. At these widths full-scale inputs are easy to write, so the bench can reach both clamp directions and also the exact ±limit boundary where no clamp may occur. A single nonzero sample on an odd lane isolates the swap-and-negate rotation on bins 1 and 3. Back-to-back sets, and idle cycles with changing inputs, exercise the pipeline's strobe timing and its holding of results.

// File: rtl/dft4_pkg.sv
// Package: shared constants of the four-point DFT butterfly.
// Assumes a fixed transform size of four; the pair count follows from it.
package dft4_pkg;
    localparam int NPT  = 4;        // points per transform
    localparam int HALF = NPT / 2;  // sample pairs combined in stage one

    // Output bin lanes, natural order.
    typedef enum int {
        BIN0 = 0,
        BIN1 = 1,
        BIN2 = 2,
        BIN3 = 3
    } bin_e;
endpackage

// File: rtl/dft4_sat.sv
// Module: dft4_sat
// Clamps a wide two's-complement value into OW bits and flags the clamp.
// Assumes IW > OW. Purely combinational.
module dft4_sat #(
    parameter int IW = 18,
    parameter int OW = 16
) (
    input  logic [IW-1:0] x,
    output logic [OW-1:0] y,
    output logic          clip
);
    localparam int TW = IW - OW + 1;

    logic [TW-1:0] top_bits;
    assign top_bits = x[IW-1:OW-1];

    // Value fits when every bit above the output sign equals that sign.
    always_comb begin
        clip = !((&top_bits) || !(|top_bits));
        if (!clip)
            y = x[OW-1:0];
        else if (x[IW-1])
            y = {1'b1, {(OW-1){1'b0}}};
        else
            y = {1'b0, {(OW-1){1'b1}}};
    end
endmodule

// File: rtl/dft4_stage1.sv
// Module: dft4_stage1
// First butterfly stage: registered sum and difference of samples k and
// k+2 for each pair, real and imaginary separately, one guard bit added.
// Assumes synchronous active-low reset; data registers load only on valid.
module dft4_stage1
    import dft4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NPT-1:0][DW-1:0]     a_re,
    input  logic [NPT-1:0][DW-1:0]     a_im,
    output logic                       s1_valid,
    output logic [HALF-1:0][DW:0]      sum_re,
    output logic [HALF-1:0][DW:0]      sum_im,
    output logic [HALF-1:0][DW:0]      dif_re,
    output logic [HALF-1:0][DW:0]      dif_im
);
    localparam int SW = DW + 1;

    logic [HALF-1:0][SW-1:0] sum_re_d, sum_im_d, dif_re_d, dif_im_d;

    for (genvar k = 0; k < HALF; k++) begin : g_pair
        logic [SW-1:0] lo_re, hi_re, lo_im, hi_im;
        assign lo_re = {a_re[k][DW-1], a_re[k]};
        assign hi_re = {a_re[k+HALF][DW-1], a_re[k+HALF]};
        assign lo_im = {a_im[k][DW-1], a_im[k]};
        assign hi_im = {a_im[k+HALF][DW-1], a_im[k+HALF]};
        assign sum_re_d[k] = lo_re + hi_re;
        assign sum_im_d[k] = lo_im + hi_im;
        assign dif_re_d[k] = lo_re - hi_re;
        assign dif_im_d[k] = lo_im - hi_im;
    end

    // Register the pair sums and differences and track the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            sum_re   <= '0;
            sum_im   <= '0;
            dif_re   <= '0;
            dif_im   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                sum_re <= sum_re_d;
                sum_im <= sum_im_d;
                dif_re <= dif_re_d;
                dif_im <= dif_im_d;
            end
        end
    end
endmodule

// File: rtl/dft4_stage2.sv
// Module: dft4_stage2
// Second butterfly stage: combines pair results into bins 0..3, applies the
// -j rotation to the odd-pair difference by swap and negate, clamps each
// component to DW bits and registers bins plus the overflow flag.
// Assumes inputs are DW+1 bits wide; internal results are DW+2 bits.
module dft4_stage2
    import dft4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s1_valid,
    input  logic [HALF-1:0][DW:0]  sum_re,
    input  logic [HALF-1:0][DW:0]  sum_im,
    input  logic [HALF-1:0][DW:0]  dif_re,
    input  logic [HALF-1:0][DW:0]  dif_im,
    output logic                   out_valid,
    output logic [NPT-1:0][DW-1:0] out_re,
    output logic [NPT-1:0][DW-1:0] out_im,
    output logic                   ovfl
);
    localparam int WW = DW + 2;

    logic [WW-1:0] s0_re, s0_im, s1_re, s1_im, d0_re, d0_im;
    logic [WW-1:0] rot_re, rot_im;
    logic [NPT-1:0][WW-1:0] x_re, x_im;
    logic [NPT-1:0][DW-1:0] y_re, y_im;
    logic [NPT-1:0] clip_re, clip_im;

    // Sign-extend stage-one results to the working width.
    always_comb begin
        s0_re = {sum_re[0][DW], sum_re[0]};
        s0_im = {sum_im[0][DW], sum_im[0]};
        s1_re = {sum_re[1][DW], sum_re[1]};
        s1_im = {sum_im[1][DW], sum_im[1]};
        d0_re = {dif_re[0][DW], dif_re[0]};
        d0_im = {dif_im[0][DW], dif_im[0]};
    end

    // Multiply the odd-pair difference by -j: (re, im) becomes (im, -re).
    always_comb begin
        rot_re = {dif_im[1][DW], dif_im[1]};
        rot_im = WW'(0) - {dif_re[1][DW], dif_re[1]};
    end

    // Form the four bins at full working width.
    always_comb begin
        x_re[BIN0] = s0_re + s1_re;
        x_im[BIN0] = s0_im + s1_im;
        x_re[BIN2] = s0_re - s1_re;
        x_im[BIN2] = s0_im - s1_im;
        x_re[BIN1] = d0_re + rot_re;
        x_im[BIN1] = d0_im + rot_im;
        x_re[BIN3] = d0_re - rot_re;
        x_im[BIN3] = d0_im - rot_im;
    end

    for (genvar k = 0; k < NPT; k++) begin : g_clamp
        dft4_sat #(.IW(WW), .OW(DW)) u_sat_re (
            .x    (x_re[k]),
            .y    (y_re[k]),
            .clip (clip_re[k])
        );
        dft4_sat #(.IW(WW), .OW(DW)) u_sat_im (
            .x    (x_im[k]),
            .y    (y_im[k]),
            .clip (clip_im[k])
        );
    end

    // Register clamped bins, the output strobe and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ovfl      <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s1_valid;
            ovfl      <= s1_valid && ((|clip_re) || (|clip_im));
            if (s1_valid) begin
                out_re <= y_re;
                out_im <= y_im;
            end
        end
    end
endmodule

// File: rtl/dft4_butterfly.sv
// Module: dft4_butterfly (top)
// Two-cycle pipelined four-point DFT with clamping and overflow report.
// Assumes synchronous active-low reset; accepts one sample set per cycle.
module dft4_butterfly
    import dft4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [NPT-1:0][DW-1:0] in_re,
    input  logic [NPT-1:0][DW-1:0] in_im,
    output logic                   out_valid,
    output logic [NPT-1:0][DW-1:0] out_re,
    output logic [NPT-1:0][DW-1:0] out_im,
    output logic                   ovfl
);
    logic                  s1_valid;
    logic [HALF-1:0][DW:0] sum_re, sum_im, dif_re, dif_im;

    dft4_stage1 #(.DW(DW)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .a_re     (in_re),
        .a_im     (in_im),
        .s1_valid (s1_valid),
        .sum_re   (sum_re),
        .sum_im   (sum_im),
        .dif_re   (dif_re),
        .dif_im   (dif_im)
    );

    dft4_stage2 #(.DW(DW)) u_stage2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .sum_re    (sum_re),
        .sum_im    (sum_im),
        .dif_re    (dif_re),
        .dif_im    (dif_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im),
        .ovfl      (ovfl)
    );
endmodule

// File: rtl/dft4_butterfly_chk.sv
// Module: dft4_butterfly_chk
// Property checker bound to dft4_butterfly: strobe timing, reset state,
// overflow consistency and holding of results between valid sets.
module dft4_butterfly_chk
    import dft4_pkg::*;
#(
    parameter int DW = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   s1_valid,
    input logic                   out_valid,
    input logic [NPT-1:0][DW-1:0] out_re,
    input logic [NPT-1:0][DW-1:0] out_im,
    input logic                   ovfl
);
    localparam logic [DW-1:0] POS_RAIL = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_RAIL = {1'b1, {(DW-1){1'b0}}};

    logic rail_hit;

    // Flag whether any output component sits on a clamp limit.
    always_comb begin
        rail_hit = 1'b0;
        for (int k = 0; k < NPT; k++) begin
            if (out_re[k] == POS_RAIL || out_re[k] == NEG_RAIL ||
                out_im[k] == POS_RAIL || out_im[k] == NEG_RAIL)
                rail_hit = 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !ovfl));

    // R2
    strobe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R9
    ovfl_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl |-> out_valid);

    // R9
    ovfl_on_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl |-> rail_hit);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(out_re) && $stable(out_im)));
endmodule

bind dft4_butterfly dft4_butterfly_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .s1_valid  (s1_valid),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .ovfl      (ovfl)
);

// File: tb/dft4_butterfly_bench.sv
`timescale 1ns/1ps
// Directed bench for dft4_butterfly: one task per scenario, each checking
// its own results against a reference computed from the requirements.
module dft4_butterfly_bench;
    localparam int DW    = 16;
    localparam int NP    = 4;
    localparam int MAXV  = 32767;
    localparam int MINV  = -32768;

    typedef int vec_t[NP];

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [NP-1:0][DW-1:0] in_re = '0;
    logic [NP-1:0][DW-1:0] in_im = '0;
    logic                  out_valid;
    logic [NP-1:0][DW-1:0] out_re;
    logic [NP-1:0][DW-1:0] out_im;
    logic                  ovfl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dft4_butterfly #(.DW(DW)) u_dft4_butterfly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im),
        .ovfl      (ovfl)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Compare one value and log failures.
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampv(input int v, inout bit ov);
        if (v > MAXV) begin ov = 1'b1; return MAXV; end
        if (v < MINV) begin ov = 1'b1; return MINV; end
        return v;
    endfunction

    // Reference transform from the requirement formulas.
    task automatic model(input vec_t ar, input vec_t ai,
                         output vec_t er, output vec_t ei, output bit ov);
        int wr[NP];
        int wi[NP];
        ov = 1'b0;
        wr[0] = ar[0] + ar[1] + ar[2] + ar[3];
        wi[0] = ai[0] + ai[1] + ai[2] + ai[3];
        wr[2] = (ar[0] + ar[2]) - (ar[1] + ar[3]);
        wi[2] = (ai[0] + ai[2]) - (ai[1] + ai[3]);
        wr[1] = (ar[0] - ar[2]) + (ai[1] - ai[3]);
        wi[1] = (ai[0] - ai[2]) - (ar[1] - ar[3]);
        wr[3] = (ar[0] - ar[2]) - (ai[1] - ai[3]);
        wi[3] = (ai[0] - ai[2]) + (ar[1] - ar[3]);
        for (int k = 0; k < NP; k++) begin
            er[k] = clampv(wr[k], ov);
            ei[k] = clampv(wi[k], ov);
        end
    endtask

    task automatic drive(input vec_t ar, input vec_t ai);
        in_valid = 1'b1;
        for (int k = 0; k < NP; k++) begin
            in_re[k] = DW'(ar[k]);
            in_im[k] = DW'(ai[k]);
        end
    endtask

    // Check outputs against the model; lane k carries its requirement tag.
    task automatic check_out(input string tag, input vec_t ar, input vec_t ai);
        vec_t er, ei;
        bit ov;
        string lane_req[NP] = '{"R3", "R5", "R4", "R6"};
        model(ar, ai, er, ei, ov);
        chk("R2", {tag, " out_valid"}, int'(out_valid), 1);
        for (int k = 0; k < NP; k++) begin
            chk(lane_req[k], $sformatf("%s bin%0d re", tag, k), int'($signed(out_re[k])), er[k]);
            chk(lane_req[k], $sformatf("%s bin%0d im", tag, k), int'($signed(out_im[k])), ei[k]);
        end
        chk("R9", {tag, " ovfl"}, int'(ovfl), int'(ov));
    endtask

    // Apply one set at a negedge and check it two edges later.
    task automatic apply_one(input string tag, input vec_t ar, input vec_t ai);
        drive(ar, ai);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", {tag, " strobe not early"}, int'(out_valid), 0);
        @(negedge clk);
        check_out(tag, ar, ai);
    endtask

    task automatic t_reset();
        chk("R1", "reset out_valid", int'(out_valid), 0);
        chk("R1", "reset ovfl", int'(ovfl), 0);
    endtask

    task automatic t_dc();
        apply_one("dc", '{100, 100, 100, 100}, '{-50, -50, -50, -50});
        @(negedge clk);
        chk("R2", "dc strobe falls", int'(out_valid), 0);
    endtask

    task automatic t_mixed();
        apply_one("mixed", '{1200, -340, 57, 8000}, '{-999, 4321, -12, 600});
        apply_one("mixed2", '{-7, 3, 11, -19}, '{5, -2, 13, 17});
    endtask

    // A lone sample on lane 1 isolates the -j rotation on bins 1 and 3.
    task automatic t_rotation();
        apply_one("rot", '{0, 0, 0, 0}, '{0, 1000, 0, 0});
        chk("R5", "rot bin1 re is +im1", int'($signed(out_re[1])), 1000);
        chk("R6", "rot bin3 re is -im1", int'($signed(out_re[3])), -1000);
        apply_one("rot2", '{0, 0, 0, 2500}, '{0, 0, 0, 0});
        chk("R5", "rot2 bin1 im is +re3", int'($signed(out_im[1])), 2500);
        chk("R6", "rot2 bin3 im is -re3", int'($signed(out_im[3])), -2500);
    endtask

    task automatic t_stream();
        vec_t r0 = '{10, 20, 30, 40};
        vec_t i0 = '{-1, -2, -3, -4};
        vec_t r1 = '{-500, 250, 125, -60};
        vec_t i1 = '{7, 77, 777, 7777};
        vec_t r2 = '{31000, -31000, 15, 0};
        vec_t i2 = '{0, 9, -9, 100};
        drive(r0, i0);
        @(negedge clk); drive(r1, i1);
        @(negedge clk); drive(r2, i2);
        check_out("R7 stream0", r0, i0);
        @(negedge clk); in_valid = 1'b0;
        check_out("R7 stream1", r1, i1);
        @(negedge clk);
        check_out("R7 stream2", r2, i2);
    endtask

    task automatic t_sat();
        apply_one("satpos", '{MAXV, MAXV, MAXV, MAXV}, '{0, 0, 0, 0});
        chk("R8", "satpos bin0 re", int'($signed(out_re[0])), MAXV);
        chk("R9", "satpos ovfl", int'(ovfl), 1);
        apply_one("satneg", '{MINV, MAXV, MINV, MAXV}, '{0, 0, 0, 0});
        chk("R8", "satneg bin2 re", int'($signed(out_re[2])), MINV);
        chk("R9", "satneg ovfl", int'(ovfl), 1);
        apply_one("edge", '{MAXV, 0, 0, 0}, '{MINV, 0, 0, 0});
        chk("R8", "edge bin3 re exact", int'($signed(out_re[3])), MAXV);
        chk("R8", "edge bin1 im exact", int'($signed(out_im[1])), MINV);
        chk("R9", "edge no ovfl", int'(ovfl), 0);
    endtask

    // Inputs change while the strobe is low; the last result must stay.
    task automatic t_hold();
        vec_t hr = '{123, -456, 789, -1011};
        vec_t hi = '{-5, 6, -7, 8};
        vec_t er, ei;
        bit ov;
        apply_one("hold", hr, hi);
        model(hr, hi, er, ei, ov);
        in_re = {4{16'h7abc}};
        in_im = {4{16'h8123}};
        repeat (3) @(negedge clk);
        chk("R10", "hold out_valid", int'(out_valid), 0);
        chk("R10", "hold ovfl", int'(ovfl), 0);
        for (int k = 0; k < NP; k++) begin
            chk("R10", $sformatf("hold bin%0d re", k), int'($signed(out_re[k])), er[k]);
            chk("R10", $sformatf("hold bin%0d im", k), int'($signed(out_im[k])), ei[k]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dc();
        t_mixed();
        t_rotation();
        t_stream();
        t_sat();
        t_hold();
        repeat (2) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule